// File: doc/BRIEF.md
# Paired Rule Combiner and Defuzzifier

This block is the back end of a zero-order fuzzy controller that works only on the rules active for the current input sample. An upstream stage presents the active rules two at a time, in lanes, over two consecutive pairs per input set. For each rule the block gets two 4-bit membership degrees, a 2-bit antecedent enable and an 8-bit signed singleton consequent. It masks the degrees, takes their minimum as the rule strength, weights the consequent by that strength, and keeps running totals of the strengths and the weighted consequents.

When the last pair of a set has been summed, the block divides the weighted total by the strength total in one pass. It looks up a 17-bit reciprocal of the strength total, multiplies, shifts and clamps the result into a 12-bit signed output. Strength totals of zero and one take dedicated paths. A set can start every second clock, and a one-cycle valid strobe marks each result.

Top module: `fzd_pair_defuzz`

## Requirements
- R1: Per lane, enable bit 1 gates degree 0 and enable bit 0 gates degree 1. With code 11 both degrees are used, 10 uses degree 0 and replaces degree 1 with 15, 01 replaces degree 0 with 15 and uses degree 1.
- R2: A lane whose enable code is 00 adds zero strength and zero weighted consequent to the totals, whatever its degrees and consequent are.
- R3: A rule's strength is the smaller of its two selected degrees. Its weighted consequent is the strength times the consequent read as 8-bit two's complement.
- R4: A pair with `in_valid_i` and `in_first_i` high starts a set and discards any earlier partial totals. The next valid pair with `in_first_i` low ends the set. The divisor is the sum of the four strengths and the dividend is the sum of the four weighted consequents.
- R5: For a divisor D of 2 or more, the output is floor(N * floor(65536 / D) / 65536) for dividend N, clamped to the range -2048..2047.
- R6: A divisor of zero gives an output of 0.
- R7: A divisor of one gives an output equal to the dividend.
- R8: `y_valid_o` is high for exactly one cycle per completed set. It rises after the sixth rising edge, counting the edge that samples the set's final pair as the first. `y_o` keeps its last value between results and is 0 after reset.
- R9: Sets may follow each other with no idle cycle, so a new set starts every second clock. Each result depends only on its own set.
- R10: Pairs with `in_valid_i` low are ignored. A valid pair with `in_first_i` low that arrives when no set is open is also ignored. Neither kind changes the totals or produces a result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Rule pair present this cycle |
| in_first_i | input | 1 | Pair is the first of an input set |
| deg0_i | input | 8 | Degree 0 per lane, lane 0 in bits 3:0 |
| deg1_i | input | 8 | Degree 1 per lane, lane 0 in bits 3:0 |
| sel_i | input | 4 | Antecedent enable per lane, lane 0 in bits 1:0 |
| cons_i | input | 16 | Signed consequent per lane, lane 0 in bits 7:0 |
| y_o | output | 12 | Signed defuzzified result |
| y_valid_o | output | 1 | One-cycle strobe for a new result |

## Verification
The unit-divisor path is the hardest case to reach from the ports. It needs a set in which exactly one lane has strength 1 and every other lane is off or has a zero degree. The stimulus builds that set on purpose, with negative and positive consequents. The zero-divisor case comes from sets in which every lane is disabled while carrying full degrees. A directed restart and gapped, stray pairs cover the set framing, and a long run of back-to-back random sets stresses the pipeline at its full rate.

// File: rtl/fzd_pkg.sv
package fzd_pkg;

    // Antecedent enable codes for one rule lane
    typedef enum logic [1:0] {
        SEL_OFF   = 2'b00,
        SEL_ONLY1 = 2'b01,
        SEL_ONLY0 = 2'b10,
        SEL_BOTH  = 2'b11
    } sel_t;

endpackage

// File: rtl/fzd_rule_lane.sv
module fzd_rule_lane
    import fzd_pkg::*;
#(
    parameter int DEG_W  = 4,
    parameter int CONS_W = 8,
    parameter int IMP_W  = DEG_W + CONS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEG_W-1:0]  deg0_i,
    input  logic [DEG_W-1:0]  deg1_i,
    input  logic [1:0]        sel_i,
    input  logic [CONS_W-1:0] cons_i,
    output logic [DEG_W-1:0]  theta_o,
    output logic [IMP_W-1:0]  impl_o
);

    localparam logic [DEG_W-1:0] DEG_FULL = '1;

    typedef struct packed {
        logic [DEG_W-1:0]  theta;
        logic [CONS_W-1:0] cons;
    } st1_t;

    typedef struct packed {
        logic [DEG_W-1:0] theta;
        logic [IMP_W-1:0] impl;
    } st2_t;

    st1_t s1_d, s1_q;
    st2_t s2_d, s2_q;

    logic [DEG_W-1:0]        eff0, eff1;
    logic signed [IMP_W-1:0] th_x, cn_x;

    always_comb begin
        eff0 = DEG_FULL;
        eff1 = DEG_FULL;
        unique case (sel_t'(sel_i))
            SEL_BOTH:  begin eff0 = deg0_i;   eff1 = deg1_i;   end
            SEL_ONLY0: begin eff0 = deg0_i;   eff1 = DEG_FULL; end
            SEL_ONLY1: begin eff0 = DEG_FULL; eff1 = deg1_i;   end
            default:   begin eff0 = '0;       eff1 = '0;       end
        endcase
        s1_d.theta = (eff0 < eff1) ? eff0 : eff1;
        s1_d.cons  = cons_i;

        th_x        = IMP_W'({1'b0, s1_q.theta});
        cn_x        = IMP_W'($signed(s1_q.cons));
        s2_d.theta  = s1_q.theta;
        s2_d.impl   = th_x * cn_x;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign theta_o = s2_q.theta;
    assign impl_o  = s2_q.impl;

endmodule

// File: rtl/fzd_integrator.sv
module fzd_integrator #(
    parameter int LANES = 2,
    parameter int PAIRS = 2,
    parameter int DEG_W = 4,
    parameter int IMP_W = 13,
    parameter int TS_W  = DEG_W + $clog2(LANES),
    parameter int IS_W  = IMP_W + $clog2(LANES),
    parameter int DIV_W = TS_W + $clog2(PAIRS),
    parameter int DVD_W = IS_W + $clog2(PAIRS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid_i,
    input  logic                    first_i,
    input  logic                    last_i,
    input  logic [LANES*DEG_W-1:0]  theta_i,
    input  logic [LANES*IMP_W-1:0]  impl_i,
    output logic [DIV_W-1:0]        divisor_o,
    output logic signed [DVD_W-1:0] dividend_o,
    output logic                    done_o
);

    typedef struct packed {
        logic            v;
        logic            f;
        logic            l;
        logic [TS_W-1:0] th;
        logic [IS_W-1:0] im;
    } sum_t;

    typedef struct packed {
        logic             done;
        logic [DIV_W-1:0] dv;
        logic [DVD_W-1:0] dd;
    } acc_t;

    sum_t sum_d, sum_q;
    acc_t acc_d, acc_q;

    logic [TS_W-1:0]        th_sum;
    logic signed [IS_W-1:0] im_sum;

    always_comb begin
        th_sum = '0;
        im_sum = '0;
        for (int i = 0; i < LANES; i++) begin
            th_sum = th_sum + TS_W'(theta_i[i*DEG_W +: DEG_W]);
            im_sum = im_sum + IS_W'($signed(impl_i[i*IMP_W +: IMP_W]));
        end
        sum_d.v  = valid_i;
        sum_d.f  = first_i;
        sum_d.l  = last_i;
        sum_d.th = th_sum;
        sum_d.im = im_sum;

        acc_d      = acc_q;
        acc_d.done = sum_q.v & sum_q.l;
        if (sum_q.v) begin
            if (sum_q.f) begin
                acc_d.dv = DIV_W'(sum_q.th);
                acc_d.dd = DVD_W'($signed(sum_q.im));
            end else begin
                acc_d.dv = acc_q.dv + DIV_W'(sum_q.th);
                acc_d.dd = acc_q.dd + DVD_W'($signed(sum_q.im));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            acc_q <= '0;
        end else begin
            sum_q <= sum_d;
            acc_q <= acc_d;
        end
    end

    assign divisor_o  = acc_q.dv;
    assign dividend_o = $signed(acc_q.dd);
    assign done_o     = acc_q.done;

endmodule

// File: rtl/fzd_recip_div.sv
module fzd_recip_div #(
    parameter int DIV_W   = 6,
    parameter int DVD_W   = 15,
    parameter int OUT_W   = 12,
    parameter int FRAC    = 16,
    parameter int RECIP_W = 17
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    done_i,
    input  logic [DIV_W-1:0]        divisor_i,
    input  logic signed [DVD_W-1:0] dividend_i,
    output logic [OUT_W-1:0]        y_o,
    output logic                    y_valid_o
);

    localparam int DEPTH  = 2 ** DIV_W;
    localparam int PROD_W = DVD_W + RECIP_W + 1;
    localparam logic signed [PROD_W-1:0] OUT_MAX = PROD_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] OUT_MIN = PROD_W'(-(2 ** (OUT_W - 1)));

    // Reciprocal table, entries 0 and 1 unused (handled by dedicated paths)
    logic [RECIP_W-1:0] recip_tab [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_tab
        localparam longint unsigned RV = (g < 2) ? 0 : ((longint'(1) << FRAC) / longint'(g));
        assign recip_tab[g] = RECIP_W'(RV);
    end

    typedef struct packed {
        logic               v;
        logic               zero;
        logic               one;
        logic [RECIP_W-1:0] rc;
        logic [DVD_W-1:0]   dd;
    } rst_t;

    typedef struct packed {
        logic             v;
        logic [OUT_W-1:0] y;
    } ost_t;

    rst_t r_d, r_q;
    ost_t o_d, o_q;

    logic signed [PROD_W-1:0] a_ext, r_ext, prod, shifted;

    function automatic logic [OUT_W-1:0] clamp(input logic signed [PROD_W-1:0] x);
        if (x > OUT_MAX) return OUT_MAX[OUT_W-1:0];
        if (x < OUT_MIN) return OUT_MIN[OUT_W-1:0];
        return x[OUT_W-1:0];
    endfunction

    always_comb begin
        r_d.v    = done_i;
        r_d.zero = (divisor_i == '0);
        r_d.one  = (divisor_i == DIV_W'(1));
        r_d.rc   = recip_tab[divisor_i];
        r_d.dd   = dividend_i;

        a_ext   = PROD_W'($signed(r_q.dd));
        r_ext   = $signed({{(PROD_W - RECIP_W){1'b0}}, r_q.rc});
        prod    = a_ext * r_ext;
        shifted = prod >>> FRAC;

        o_d   = o_q;
        o_d.v = r_q.v;
        if (r_q.v) begin
            if (r_q.zero)     o_d.y = '0;
            else if (r_q.one) o_d.y = clamp(a_ext);
            else              o_d.y = clamp(shifted);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
            o_q <= '0;
        end else begin
            r_q <= r_d;
            o_q <= o_d;
        end
    end

    assign y_o       = o_q.y;
    assign y_valid_o = o_q.v;

endmodule

// File: rtl/fzd_pair_defuzz.sv
module fzd_pair_defuzz
    import fzd_pkg::*;
#(
    parameter int LANES   = 2,
    parameter int PAIRS   = 2,
    parameter int DEG_W   = 4,
    parameter int CONS_W  = 8,
    parameter int OUT_W   = 12,
    parameter int FRAC    = 16,
    parameter int RECIP_W = 17
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid_i,
    input  logic                    in_first_i,
    input  logic [LANES*DEG_W-1:0]  deg0_i,
    input  logic [LANES*DEG_W-1:0]  deg1_i,
    input  logic [LANES*2-1:0]      sel_i,
    input  logic [LANES*CONS_W-1:0] cons_i,
    output logic [OUT_W-1:0]        y_o,
    output logic                    y_valid_o
);

    localparam int IMP_W = DEG_W + CONS_W + 1;
    localparam int TS_W  = DEG_W + $clog2(LANES);
    localparam int IS_W  = IMP_W + $clog2(LANES);
    localparam int DIV_W = TS_W + $clog2(PAIRS);
    localparam int DVD_W = IS_W + $clog2(PAIRS);
    localparam int CNT_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             t1_v, t1_f, t1_l;
        logic             t2_v, t2_f, t2_l;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.t2_v = ctl_q.t1_v;
        ctl_d.t2_f = ctl_q.t1_f;
        ctl_d.t2_l = ctl_q.t1_l;
        ctl_d.t1_v = 1'b0;
        ctl_d.t1_f = 1'b0;
        ctl_d.t1_l = 1'b0;
        if (in_valid_i && in_first_i) begin
            ctl_d.t1_v = 1'b1;
            ctl_d.t1_f = 1'b1;
            ctl_d.t1_l = (PAIRS == 1);
            ctl_d.cnt  = (PAIRS == 1) ? '0 : CNT_W'(1);
        end else if (in_valid_i && (ctl_q.cnt != '0)) begin
            ctl_d.t1_v = 1'b1;
            ctl_d.t1_l = (ctl_q.cnt == CNT_W'(PAIRS - 1));
            ctl_d.cnt  = ctl_d.t1_l ? '0 : ctl_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    logic [LANES*DEG_W-1:0] lane_theta;
    logic [LANES*IMP_W-1:0] lane_impl;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fzd_rule_lane #(
            .DEG_W  (DEG_W),
            .CONS_W (CONS_W),
            .IMP_W  (IMP_W)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .deg0_i  (deg0_i[g*DEG_W +: DEG_W]),
            .deg1_i  (deg1_i[g*DEG_W +: DEG_W]),
            .sel_i   (sel_i[g*2 +: 2]),
            .cons_i  (cons_i[g*CONS_W +: CONS_W]),
            .theta_o (lane_theta[g*DEG_W +: DEG_W]),
            .impl_o  (lane_impl[g*IMP_W +: IMP_W])
        );
    end

    logic [DIV_W-1:0]        acc_divisor;
    logic signed [DVD_W-1:0] acc_dividend;
    logic                    acc_done;

    fzd_integrator #(
        .LANES (LANES),
        .PAIRS (PAIRS),
        .DEG_W (DEG_W),
        .IMP_W (IMP_W),
        .TS_W  (TS_W),
        .IS_W  (IS_W),
        .DIV_W (DIV_W),
        .DVD_W (DVD_W)
    ) u_int (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (ctl_q.t2_v),
        .first_i    (ctl_q.t2_f),
        .last_i     (ctl_q.t2_l),
        .theta_i    (lane_theta),
        .impl_i     (lane_impl),
        .divisor_o  (acc_divisor),
        .dividend_o (acc_dividend),
        .done_o     (acc_done)
    );

    fzd_recip_div #(
        .DIV_W   (DIV_W),
        .DVD_W   (DVD_W),
        .OUT_W   (OUT_W),
        .FRAC    (FRAC),
        .RECIP_W (RECIP_W)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (acc_done),
        .divisor_i  (acc_divisor),
        .dividend_i (acc_dividend),
        .y_o        (y_o),
        .y_valid_o  (y_valid_o)
    );

endmodule

// File: rtl/fzd_checker.sv
module fzd_checker #(
    parameter int DIV_W   = 6,
    parameter int DVD_W   = 15,
    parameter int OUT_W   = 12,
    parameter int MAX_DIV = 60
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    done,
    input logic [DIV_W-1:0]        divisor,
    input logic signed [DVD_W-1:0] dividend,
    input logic                    y_valid,
    input logic [OUT_W-1:0]        y
);

    logic signed [OUT_W-1:0] y_s;
    assign y_s = $signed(y);

    AST_DONE_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ##2 y_valid); // R8

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ##2 !y_valid); // R8

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |=> !y_valid); // R9

    AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && divisor == '0) |-> ##2 (y == '0)); // R6

    AST_UNIT_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && divisor == DIV_W'(1)) |-> ##2 (DVD_W'(y_s) == $past(dividend, 2))); // R7

    AST_DIVISOR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(divisor) <= MAX_DIV)); // R4

    AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !y_valid |-> $stable(y)); // R8

endmodule

bind fzd_pair_defuzz fzd_checker #(
    .DIV_W   (DIV_W),
    .DVD_W   (DVD_W),
    .OUT_W   (OUT_W),
    .MAX_DIV (LANES * PAIRS * ((2 ** DEG_W) - 1))
) u_fzd_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (acc_done),
    .divisor  (acc_divisor),
    .dividend (acc_dividend),
    .y_valid  (y_valid_o),
    .y        (y_o)
);

// File: tb/tb_fzd_pair_defuzz.sv
`timescale 1ns/1ps
module tb_fzd_pair_defuzz;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid_i = 1'b0;
    logic        in_first_i = 1'b0;
    logic [7:0]  deg0_i = '0;
    logic [7:0]  deg1_i = '0;
    logic [3:0]  sel_i = '0;
    logic [15:0] cons_i = '0;
    logic [11:0] y_o;
    logic        y_valid_o;

    fzd_pair_defuzz dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (in_valid_i),
        .in_first_i (in_first_i),
        .deg0_i     (deg0_i),
        .deg1_i     (deg1_i),
        .sel_i      (sel_i),
        .cons_i     (cons_i),
        .y_o        (y_o),
        .y_valid_o  (y_valid_o)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;
    bit monitor_on = 0;
    string cur_tag = "R8";

    int due_q[$];
    int val_q[$];
    string tag_q[$];

    int m_open = 0;
    int m_div = 0;
    int m_dvd = 0;
    int last_y = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int lane_theta(int d0, int d1, int sel);
        int e0, e1;
        if (sel == 0) return 0;
        e0 = ((sel & 2) != 0) ? d0 : 15;
        e1 = ((sel & 1) != 0) ? d1 : 15;
        return (e0 < e1) ? e0 : e1;
    endfunction

    function automatic int model_out(int n, int d);
        longint r, p, q;
        if (d == 0) return 0;
        if (d == 1) q = n;
        else begin
            r = 65536 / d;
            p = longint'(n) * r;
            q = p >>> 16;
        end
        if (q > 2047) q = 2047;
        if (q < -2048) q = -2048;
        return int'(q);
    endfunction

    task automatic report(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Compare against the reference on every clock, away from the active edge
    always @(negedge clk) begin
        if (monitor_on && !finished) begin
            if (due_q.size() != 0 && due_q[0] == cyc) begin
                report(y_valid_o === 1'b1, {tag_q[0], " valid"}, int'(y_valid_o), 1);
                report($signed(y_o) == val_q[0], {tag_q[0], " value"}, int'($signed(y_o)), val_q[0]);
                last_y = val_q[0];
                void'(due_q.pop_front());
                void'(val_q.pop_front());
                void'(tag_q.pop_front());
            end else begin
                report(y_valid_o === 1'b0, {cur_tag, " no strobe"}, int'(y_valid_o), 0);
                report($signed(y_o) == last_y, {cur_tag, " hold"}, int'($signed(y_o)), last_y);
            end
        end
    end

    task automatic send(bit v, bit f,
                        int a0, int a1, int as, int ac,
                        int b0, int b1, int bs, int bc, string tag);
        int th_a, th_b;
        @(negedge clk);
        in_valid_i = v;
        in_first_i = f;
        deg0_i = {4'(b0), 4'(a0)};
        deg1_i = {4'(b1), 4'(a1)};
        sel_i  = {2'(bs), 2'(as)};
        cons_i = {8'(bc), 8'(ac)};
        if (v) begin
            th_a = lane_theta(a0, a1, as);
            th_b = lane_theta(b0, b1, bs);
            if (f) begin
                m_open = 1;
                m_div = th_a + th_b;
                m_dvd = th_a * ac + th_b * bc;
            end else if (m_open == 1) begin
                m_open = 0;
                m_div += th_a + th_b;
                m_dvd += th_a * ac + th_b * bc;
                due_q.push_back(cyc + 6);
                val_q.push_back(model_out(m_dvd, m_div));
                tag_q.push_back(tag);
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) send(0, 0, 7, 9, 3, 55, 12, 4, 3, -99, "R10");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // Reset state (R8)
        report(y_valid_o === 1'b0, "R8 reset valid", int'(y_valid_o), 0);
        report(y_o === 12'd0, "R8 reset value", int'(y_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        monitor_on = 1;
        idle(2);

        // R1 and R2: each enable code, one disabled lane with full degrees
        cur_tag = "R1";
        send(1, 1, 9, 3, 2, 100, 2, 7, 1, -50, "R1");
        send(1, 0, 4, 11, 3, 20, 15, 15, 0, 127, "R1 R2");
        idle(8);

        // R3: minimum and signed product
        cur_tag = "R3";
        send(1, 1, 5, 12, 3, 30, 13, 6, 3, -90, "R3");
        send(1, 0, 8, 8, 3, -128, 3, 14, 3, 127, "R3");
        idle(8);

        // R6 and R2: every lane disabled
        cur_tag = "R6";
        send(1, 1, 15, 15, 0, 127, 15, 15, 0, -128, "R6 R2");
        send(1, 0, 15, 15, 0, 100, 15, 15, 0, 100, "R6 R2");
        idle(8);

        // R7: single rule of strength one, both signs
        cur_tag = "R7";
        send(1, 1, 1, 15, 3, -77, 9, 9, 0, 40, "R7");
        send(1, 0, 0, 12, 3, 99, 6, 0, 3, 50, "R7");
        idle(8);
        send(1, 1, 0, 0, 0, 0, 15, 1, 1, 123, "R7");
        send(1, 0, 0, 5, 2, -60, 0, 0, 0, 0, "R7");
        idle(8);

        // R5: extremes of strength and consequent
        cur_tag = "R5";
        send(1, 1, 15, 15, 3, -128, 15, 15, 3, -128, "R5");
        send(1, 0, 15, 15, 3, -128, 15, 15, 3, -128, "R5");
        send(1, 1, 15, 15, 3, 127, 15, 15, 3, 127, "R5 R9");
        send(1, 0, 15, 15, 3, 127, 15, 15, 3, 127, "R5 R9");
        idle(8);

        // R4: restart discards the partial set
        cur_tag = "R4";
        send(1, 1, 15, 15, 3, 127, 15, 15, 3, 127, "R4");
        send(1, 1, 3, 7, 3, -10, 6, 2, 3, 44, "R4");
        send(1, 0, 9, 11, 3, 5, 1, 4, 3, -3, "R4");
        idle(8);

        // R10: stray pairs while idle, gaps inside a set
        cur_tag = "R10";
        send(1, 0, 15, 15, 3, 127, 15, 15, 3, 127, "R10");
        send(1, 0, 15, 15, 3, -128, 15, 15, 3, -128, "R10");
        idle(8);
        send(1, 1, 6, 10, 3, 70, 12, 12, 2, -20, "R10");
        idle(3);
        send(1, 0, 2, 14, 1, 33, 7, 7, 3, -5, "R10");
        send(1, 0, 15, 15, 3, 127, 15, 15, 3, 127, "R10");
        idle(8);

        // R9 and R5: back-to-back random sets
        cur_tag = "R9";
        void'($urandom(17));
        for (int s = 0; s < 60; s++) begin
            for (int p = 0; p < 2; p++) begin
                send(1, p == 0,
                     $urandom_range(15), $urandom_range(15), $urandom_range(3),
                     int'($urandom_range(255)) - 128,
                     $urandom_range(15), $urandom_range(15), $urandom_range(3),
                     int'($urandom_range(255)) - 128, "R9 R5");
            end
        end
        idle(10);

        if (due_q.size() != 0) report(0, "R8 missing results", 0, due_q.size());
        finish_run();
    end

endmodule